// File: doc/BRIEF.md
# Ordered Store Queue with Byte Forwarding

This block sits between one in-order core pipeline and the memory system and keeps the core's memory traffic in total store order. Committed stores are written into a small circular queue, each with its address, data and byte-enable mask. The queue writes them to memory one at a time on a dedicated write channel, always oldest first. Loads and atomic operations use a separate read channel. A load may therefore finish while older stores are still waiting in the queue. This is the only reordering the block permits.

A load first looks in the queue. For every byte it asks for, the youngest queued store that writes that byte supplies the value. If every requested byte is found in the queue, the load completes without a memory access. Otherwise one read goes out, and the reply is merged byte by byte with the forwarded data. Bytes the load did not ask for come back as zero.

An atomic read-modify-write is a barrier in both directions. It waits until the queue has fully drained and then goes to memory as a single request. Until its reply has been handed back, no store or load is accepted. Only one operation (store, load or atomic) is taken per cycle. A load or atomic holds off every later operation until its own response has been given.

Top module: `tso_store_queue`

## Requirements
- R1: Synchronous reset empties the queue and drops any atomic in progress. In the first cycle after reset, drainValid, full, busy, ldRespValid and amoRespValid are low and stReady is high.
- R2: A store is taken on a cycle with stValid and stReady both high. After DEPTH (default 8) stores that have not drained, full is high and stReady is low.
- R3: Queued stores appear on the drain channel strictly in the order they were taken, each exactly once. An entry leaves only on a cycle with drainValid and drainReady both high. While drainReady is low, address, data and mask are held. Once drained, memory holds the program-order image.
- R4: A load that needs any byte not held in the queue issues exactly one read and completes even while older stores stay queued (full may remain high).
- R5: Forwarding works per byte. For each requested byte (mask bit b selects data bits 8b+7..8b), the youngest queued store to the same word with that mask bit set supplies the byte.
- R6: A load whose requested bytes are all held in the queue issues no read. ldRespValid is high in the cycle after the load is taken.
- R7: For a load needing memory, covered bytes come from the queue and the others from the read reply. Bytes whose mask bit is clear return zero.
- R8: After a load is taken, stReady and ldReady stay low until its response cycle has passed. ldRespValid and amoRespValid are never high together.
- R9: An atomic's read request is issued only when the queue is empty, that is, after every older store has drained. busy is high from acceptance through the response cycle, and stReady and ldReady are low while busy.
- R10: An atomic goes out as one read request with rdReqAtomic high, carrying its address, operand and operation code (0 swap, 1 add, 2 and, 3 or, applied by memory). No other read request is issued before its reply. respData with amoRespValid equals the memory's reply (the old word).

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous reset, active high |
| stValid | input | 1 | Store offered |
| stReady | output | 1 | Store can be taken this cycle |
| stAddr | input | ADDR_W | Store byte address (word aligned) |
| stData | input | DATA_W | Store data |
| stMask | input | DATA_W/8 | Store byte enables |
| full | output | 1 | Every queue entry is occupied |
| ldValid | input | 1 | Load offered |
| ldReady | output | 1 | Load can be taken this cycle |
| ldAddr | input | ADDR_W | Load word address |
| ldMask | input | DATA_W/8 | Requested bytes |
| ldRespValid | output | 1 | Load result on respData |
| amoValid | input | 1 | Atomic offered |
| amoReady | output | 1 | Atomic can be taken this cycle |
| amoAddr | input | ADDR_W | Atomic word address |
| amoData | input | DATA_W | Atomic operand |
| amoOp | input | 2 | Atomic operation code |
| amoRespValid | output | 1 | Atomic old value on respData |
| busy | output | 1 | Atomic in progress |
| respData | output | DATA_W | Response data for load or atomic |
| drainValid | output | 1 | Oldest queued store offered to memory |
| drainReady | input | 1 | Memory takes the drain write |
| drainAddr | output | ADDR_W | Drain write address |
| drainData | output | DATA_W | Drain write data |
| drainMask | output | DATA_W/8 | Drain write byte enables |
| rdReqValid | output | 1 | Read or atomic request offered |
| rdReqReady | input | 1 | Memory takes the request |
| rdReqAtomic | output | 1 | Request is an atomic |
| rdReqAddr | output | ADDR_W | Request address |
| rdReqMask | output | DATA_W/8 | Request byte enables (all ones for atomics) |
| rdReqData | output | DATA_W | Atomic operand |
| rdReqOp | output | 2 | Atomic operation code |
| rdRespValid | input | 1 | Read reply valid |
| rdRespData | input | DATA_W | Read reply data |

## Verification
The properties assume the core offers at most one of stValid, ldValid and amoValid in a cycle. They also assume memory replies exactly once per accepted read, no earlier than the cycle after acceptance, and that addresses are word aligned. The bench drives one operation at a time through tasks that wait for the matching ready. Its memory model answers every read one cycle after taking it and never sends an unrequested reply. Drain back-pressure comes either from an explicit stall or from a pseudo-random pattern, so forwarding is exercised against both drained and still-queued stores.

// File: rtl/tso_sq_pkg.sv
package tso_sq_pkg;

  // Strobes from the control unit to the datapath, one cycle wide each.
  typedef struct packed {
    logic enq;        // take the offered store into the queue
    logic ldAccept;   // capture load request and forwarded bytes
    logic ldMerge;    // merge read reply into the load result
    logic amoAccept;  // capture atomic request
    logic amoResp;    // capture atomic reply
  } sqStrobe_t;

  typedef enum logic [2:0] {
    S_IDLE,
    S_LDREQ,
    S_LDWAIT,
    S_LDRESP,
    S_AMODRAIN,
    S_AMOREQ,
    S_AMOWAIT,
    S_AMORESP
  } sqState_t;

endpackage

// File: rtl/tso_sq_data.sv
module tso_sq_data
  import tso_sq_pkg::*;
#(
  parameter int DEPTH  = 8,   // power of two
  parameter int ADDR_W = 32,
  parameter int DATA_W = 32
) (
  input  logic                clk,
  input  logic                rst,
  input  sqStrobe_t           strobe,
  input  logic [ADDR_W-1:0]   stAddr,
  input  logic [DATA_W-1:0]   stData,
  input  logic [DATA_W/8-1:0] stMask,
  input  logic [ADDR_W-1:0]   ldAddr,
  input  logic [DATA_W/8-1:0] ldMask,
  input  logic [ADDR_W-1:0]   amoAddr,
  input  logic [DATA_W-1:0]   amoData,
  input  logic [1:0]          amoOp,
  input  logic                drainReady,
  input  logic [DATA_W-1:0]   rdRespData,
  output logic                full,
  output logic                empty,
  output logic                ldNeedMem,
  output logic                drainValid,
  output logic [ADDR_W-1:0]   drainAddr,
  output logic [DATA_W-1:0]   drainData,
  output logic [DATA_W/8-1:0] drainMask,
  output logic [ADDR_W-1:0]   reqAddr,
  output logic [DATA_W/8-1:0] reqMask,
  output logic [DATA_W-1:0]   reqData,
  output logic [1:0]          reqOp,
  output logic [DATA_W-1:0]   respData
);
  localparam int BYTES = DATA_W / 8;
  localparam int PTR_W = $clog2(DEPTH);
  localparam int OFF_W = $clog2(BYTES);
  localparam int CNT_W = PTR_W + 1;

  logic [ADDR_W-1:0] entAddr [DEPTH];
  logic [DATA_W-1:0] entData [DEPTH];
  logic [BYTES-1:0]  entMask [DEPTH];
  logic [PTR_W-1:0]  head, tail;
  logic [CNT_W-1:0]  count;
  logic              deq;
  logic [DEPTH-1:0]  entHit;

  logic [DATA_W-1:0] fwdData;
  logic [BYTES-1:0]  fwdCover;
  logic [DATA_W-1:0] mergeData;

  logic [ADDR_W-1:0] ldAddrQ, amoAddrQ;
  logic [BYTES-1:0]  ldMaskQ, fwdCoverQ;
  logic [DATA_W-1:0] fwdDataQ, amoDataQ, respDataQ;
  logic [1:0]        amoOpQ;
  logic              reqIsAmo;

  assign full       = (count == CNT_W'(DEPTH));
  assign empty      = (count == '0);
  assign drainValid = !empty;
  assign drainAddr  = entAddr[head];
  assign drainData  = entData[head];
  assign drainMask  = entMask[head];
  assign deq        = drainValid && drainReady;

  // Per-slot liveness and word match against the offered load.
  for (genvar e = 0; e < DEPTH; e++) begin : g_hit
    logic [PTR_W-1:0] age;
    assign age = PTR_W'(e) - head;
    assign entHit[e] = ({1'b0, age} < count) &&
                       (entAddr[e][ADDR_W-1:OFF_W] == ldAddr[ADDR_W-1:OFF_W]);
  end

  // Walk oldest to youngest so the youngest covering store wins per byte.
  always_comb begin
    fwdData  = '0;
    fwdCover = '0;
    for (int i = 0; i < DEPTH; i++) begin
      if (entHit[head + PTR_W'(i)]) begin
        for (int b = 0; b < BYTES; b++) begin
          if (entMask[head + PTR_W'(i)][b] && ldMask[b]) begin
            fwdData[8*b +: 8] = entData[head + PTR_W'(i)][8*b +: 8];
            fwdCover[b]       = 1'b1;
          end
        end
      end
    end
  end

  assign ldNeedMem = |(ldMask & ~fwdCover);

  always_comb begin
    for (int b = 0; b < BYTES; b++) begin
      if (!ldMaskQ[b])       mergeData[8*b +: 8] = 8'h00;
      else if (fwdCoverQ[b]) mergeData[8*b +: 8] = fwdDataQ[8*b +: 8];
      else                   mergeData[8*b +: 8] = rdRespData[8*b +: 8];
    end
  end

  // Queue storage, no reset needed on payload.
  always_ff @(posedge clk) begin
    if (strobe.enq) begin
      entAddr[tail] <= stAddr;
      entData[tail] <= stData;
      entMask[tail] <= stMask;
    end
  end

  always_ff @(posedge clk) begin
    if (rst) begin
      head  <= '0;
      tail  <= '0;
      count <= '0;
    end else begin
      if (strobe.enq) tail <= tail + 1'b1;
      if (deq)        head <= head + 1'b1;
      case ({strobe.enq, deq})
        2'b10:   count <= count + 1'b1;
        2'b01:   count <= count - 1'b1;
        default: ;
      endcase
    end
  end

  always_ff @(posedge clk) begin
    if (rst) begin
      ldAddrQ   <= '0;
      ldMaskQ   <= '0;
      fwdDataQ  <= '0;
      fwdCoverQ <= '0;
      amoAddrQ  <= '0;
      amoDataQ  <= '0;
      amoOpQ    <= '0;
      respDataQ <= '0;
      reqIsAmo  <= 1'b0;
    end else begin
      if (strobe.ldAccept) begin
        ldAddrQ   <= ldAddr;
        ldMaskQ   <= ldMask;
        fwdDataQ  <= fwdData;
        fwdCoverQ <= fwdCover;
        respDataQ <= fwdData;
        reqIsAmo  <= 1'b0;
      end
      if (strobe.amoAccept) begin
        amoAddrQ <= amoAddr;
        amoDataQ <= amoData;
        amoOpQ   <= amoOp;
        reqIsAmo <= 1'b1;
      end
      if (strobe.ldMerge) respDataQ <= mergeData;
      if (strobe.amoResp) respDataQ <= rdRespData;
    end
  end

  assign reqAddr  = reqIsAmo ? amoAddrQ : ldAddrQ;
  assign reqMask  = reqIsAmo ? {BYTES{1'b1}} : ldMaskQ;
  assign reqData  = amoDataQ;
  assign reqOp    = amoOpQ;
  assign respData = respDataQ;

endmodule

// File: rtl/tso_sq_ctrl.sv
module tso_sq_ctrl
  import tso_sq_pkg::*;
(
  input  logic      clk,
  input  logic      rst,
  input  logic      stValid,
  input  logic      ldValid,
  input  logic      amoValid,
  input  logic      full,
  input  logic      empty,
  input  logic      ldNeedMem,
  input  logic      rdReqReady,
  input  logic      rdRespValid,
  output logic      stReady,
  output logic      ldReady,
  output logic      amoReady,
  output logic      busy,
  output logic      rdReqValid,
  output logic      rdReqAtomic,
  output logic      ldRespValid,
  output logic      amoRespValid,
  output sqStrobe_t strobe
);
  sqState_t state, stateNext;
  logic     idle;

  assign idle     = (state == S_IDLE);
  // One operation per cycle; atomic beats load beats store.
  assign amoReady = idle;
  assign ldReady  = idle && !amoValid;
  assign stReady  = idle && !full && !ldValid && !amoValid;

  assign strobe.amoAccept = amoValid && amoReady;
  assign strobe.ldAccept  = ldValid && ldReady;
  assign strobe.enq       = stValid && stReady;
  assign strobe.ldMerge   = (state == S_LDWAIT) && rdRespValid;
  assign strobe.amoResp   = (state == S_AMOWAIT) && rdRespValid;

  assign rdReqValid   = (state == S_LDREQ) || (state == S_AMOREQ);
  assign rdReqAtomic  = (state == S_AMOREQ);
  assign ldRespValid  = (state == S_LDRESP);
  assign amoRespValid = (state == S_AMORESP);
  assign busy = (state == S_AMODRAIN) || (state == S_AMOREQ) ||
                (state == S_AMOWAIT)  || (state == S_AMORESP);

  always_comb begin
    stateNext = state;
    case (state)
      S_IDLE: begin
        if (strobe.amoAccept)     stateNext = S_AMODRAIN;
        else if (strobe.ldAccept) stateNext = ldNeedMem ? S_LDREQ : S_LDRESP;
      end
      S_LDREQ:    if (rdReqReady)  stateNext = S_LDWAIT;
      S_LDWAIT:   if (rdRespValid) stateNext = S_LDRESP;
      S_LDRESP:   stateNext = S_IDLE;
      S_AMODRAIN: if (empty)       stateNext = S_AMOREQ;
      S_AMOREQ:   if (rdReqReady)  stateNext = S_AMOWAIT;
      S_AMOWAIT:  if (rdRespValid) stateNext = S_AMORESP;
      S_AMORESP:  stateNext = S_IDLE;
      default:    stateNext = S_IDLE;
    endcase
  end

  always_ff @(posedge clk) begin
    if (rst) state <= S_IDLE;
    else     state <= stateNext;
  end

endmodule

// File: rtl/tso_store_queue.sv
module tso_store_queue
  import tso_sq_pkg::*;
#(
  parameter int DEPTH  = 8,
  parameter int ADDR_W = 32,
  parameter int DATA_W = 32
) (
  input  logic                clk,
  input  logic                rst,
  input  logic                stValid,
  output logic                stReady,
  input  logic [ADDR_W-1:0]   stAddr,
  input  logic [DATA_W-1:0]   stData,
  input  logic [DATA_W/8-1:0] stMask,
  output logic                full,
  input  logic                ldValid,
  output logic                ldReady,
  input  logic [ADDR_W-1:0]   ldAddr,
  input  logic [DATA_W/8-1:0] ldMask,
  output logic                ldRespValid,
  input  logic                amoValid,
  output logic                amoReady,
  input  logic [ADDR_W-1:0]   amoAddr,
  input  logic [DATA_W-1:0]   amoData,
  input  logic [1:0]          amoOp,
  output logic                amoRespValid,
  output logic                busy,
  output logic [DATA_W-1:0]   respData,
  output logic                drainValid,
  input  logic                drainReady,
  output logic [ADDR_W-1:0]   drainAddr,
  output logic [DATA_W-1:0]   drainData,
  output logic [DATA_W/8-1:0] drainMask,
  output logic                rdReqValid,
  input  logic                rdReqReady,
  output logic                rdReqAtomic,
  output logic [ADDR_W-1:0]   rdReqAddr,
  output logic [DATA_W/8-1:0] rdReqMask,
  output logic [DATA_W-1:0]   rdReqData,
  output logic [1:0]          rdReqOp,
  input  logic                rdRespValid,
  input  logic [DATA_W-1:0]   rdRespData
);
  sqStrobe_t strobe;
  logic      empty;
  logic      ldNeedMem;

  tso_sq_ctrl u_ctrl (
    .clk(clk), .rst(rst),
    .stValid(stValid), .ldValid(ldValid), .amoValid(amoValid),
    .full(full), .empty(empty), .ldNeedMem(ldNeedMem),
    .rdReqReady(rdReqReady), .rdRespValid(rdRespValid),
    .stReady(stReady), .ldReady(ldReady), .amoReady(amoReady),
    .busy(busy), .rdReqValid(rdReqValid), .rdReqAtomic(rdReqAtomic),
    .ldRespValid(ldRespValid), .amoRespValid(amoRespValid),
    .strobe(strobe)
  );

  tso_sq_data #(.DEPTH(DEPTH), .ADDR_W(ADDR_W), .DATA_W(DATA_W)) u_data (
    .clk(clk), .rst(rst), .strobe(strobe),
    .stAddr(stAddr), .stData(stData), .stMask(stMask),
    .ldAddr(ldAddr), .ldMask(ldMask),
    .amoAddr(amoAddr), .amoData(amoData), .amoOp(amoOp),
    .drainReady(drainReady), .rdRespData(rdRespData),
    .full(full), .empty(empty), .ldNeedMem(ldNeedMem),
    .drainValid(drainValid), .drainAddr(drainAddr),
    .drainData(drainData), .drainMask(drainMask),
    .reqAddr(rdReqAddr), .reqMask(rdReqMask),
    .reqData(rdReqData), .reqOp(rdReqOp),
    .respData(respData)
  );

endmodule

// File: rtl/tso_sq_checker.sv
module tso_sq_checker #(
  parameter int ADDR_W = 32,
  parameter int DATA_W = 32
) (
  input logic                clk,
  input logic                rst,
  input logic                stReady,
  input logic                ldReady,
  input logic                full,
  input logic                busy,
  input logic                drainValid,
  input logic                drainReady,
  input logic [ADDR_W-1:0]   drainAddr,
  input logic [DATA_W-1:0]   drainData,
  input logic [DATA_W/8-1:0] drainMask,
  input logic                rdReqValid,
  input logic                rdReqReady,
  input logic                rdReqAtomic,
  input logic                rdRespValid,
  input logic                ldRespValid,
  input logic                amoRespValid
);
  logic amoOut;

  always_ff @(posedge clk) begin
    if (rst) amoOut <= 1'b0;
    else if (rdReqValid && rdReqReady && rdReqAtomic) amoOut <= 1'b1;
    else if (rdRespValid) amoOut <= 1'b0;
  end

  // R1
  reset_clear_chk: assert property (@(posedge clk) disable iff (rst)
    $past(rst) |-> (!drainValid && !full && !busy && stReady));

  // R2
  full_blocks_chk: assert property (@(posedge clk) disable iff (rst)
    full |-> !stReady);

  // R3
  drain_hold_chk: assert property (@(posedge clk) disable iff (rst)
    (drainValid && !drainReady) |=>
      (drainValid && $stable(drainAddr) && $stable(drainData) && $stable(drainMask)));

  // R8
  resp_exclusive_chk: assert property (@(posedge clk) disable iff (rst)
    ldRespValid |-> (!amoRespValid && !ldReady && !stReady));

  // R9
  amo_after_empty_chk: assert property (@(posedge clk) disable iff (rst)
    (rdReqValid && rdReqAtomic) |-> !drainValid);

  // R9
  busy_blocks_chk: assert property (@(posedge clk) disable iff (rst)
    busy |-> (!stReady && !ldReady));

  // R10
  amo_alone_chk: assert property (@(posedge clk) disable iff (rst)
    amoOut |-> !rdReqValid);

  // R10
  req_hold_chk: assert property (@(posedge clk) disable iff (rst)
    (rdReqValid && !rdReqReady) |=> rdReqValid);

endmodule

bind tso_store_queue tso_sq_checker #(.ADDR_W(ADDR_W), .DATA_W(DATA_W)) u_chk (.*);

// File: tb/tso_store_queue_bench.sv
module tso_store_queue_bench;
  logic        clk = 1'b0;
  logic        rst;
  logic        stValid, stReady, full;
  logic [31:0] stAddr, stData;
  logic [3:0]  stMask;
  logic        ldValid, ldReady, ldRespValid;
  logic [31:0] ldAddr;
  logic [3:0]  ldMask;
  logic        amoValid, amoReady, amoRespValid, busy;
  logic [31:0] amoAddr, amoData, respData;
  logic [1:0]  amoOp;
  logic        drainValid, drainReady;
  logic [31:0] drainAddr, drainData;
  logic [3:0]  drainMask;
  logic        rdReqValid, rdReqReady, rdReqAtomic;
  logic [31:0] rdReqAddr, rdReqData;
  logic [3:0]  rdReqMask;
  logic [1:0]  rdReqOp;
  logic        rdRespValid;
  logic [31:0] rdRespData;

  int checks = 0;
  int errors = 0;
  int cyc = 0;
  bit done = 1'b0;

  logic [31:0] mem    [16];
  logic [31:0] shadow [16];
  logic [31:0] qAddr [512];
  logic [31:0] qData [512];
  logic [3:0]  qMask [512];
  int qHead = 0, qTail = 0;
  int rdCount = 0, drainCount = 0, storeCount = 0, drainsAtAmo = 0;
  bit drainStall = 1'b0, jitter = 1'b0;
  logic [15:0] lfsr = 16'hACE1;

  always #5 clk = ~clk;

  assign drainReady = !drainStall && (!jitter || lfsr[0]);
  assign rdReqReady = 1'b1;

  tso_store_queue u_tso_store_queue (.*);

  task automatic check(input bit ok, input string tag,
                       input logic [31:0] act, input logic [31:0] exp);
    checks++;
    if (!ok) begin
      errors++;
      $display("FAIL %s act=%h exp=%h", tag, act, exp);
    end
  endtask

  function automatic logic [31:0] amoApply(input logic [31:0] old, input logic [31:0] d,
                                           input logic [1:0] op);
    case (op)
      2'd0:    return d;
      2'd1:    return old + d;
      2'd2:    return old & d;
      default: return old | d;
    endcase
  endfunction

  // Memory model: read replies one cycle after acceptance, writes applied on accept.
  always @(posedge clk) begin
    lfsr <= {lfsr[14:0], lfsr[15] ^ lfsr[13] ^ lfsr[12] ^ lfsr[10]};
    if (rst) begin
      rdRespValid <= 1'b0;
      rdRespData  <= '0;
    end else begin
      rdRespValid <= 1'b0;
      if (rdReqValid && rdReqReady) begin
        logic [31:0] old;
        old = mem[rdReqAddr[5:2]];
        rdCount++;
        rdRespValid <= 1'b1;
        rdRespData  <= old;
        if (rdReqAtomic) begin
          drainsAtAmo = drainCount;
          mem[rdReqAddr[5:2]] = amoApply(old, rdReqData, rdReqOp);
        end
      end
      if (drainValid && drainReady) begin
        drainCount++;
        if (qHead == qTail) check(1'b0, "R3 drain with nothing queued", drainData, 32'h0);
        else begin
          check(drainAddr == qAddr[qHead] && drainData == qData[qHead] &&
                drainMask == qMask[qHead], "R3 drain order", drainData, qData[qHead]);
          qHead++;
        end
        for (int b = 0; b < 4; b++)
          if (drainMask[b]) mem[drainAddr[5:2]][8*b +: 8] = drainData[8*b +: 8];
      end
      if (stValid && stReady) begin
        qAddr[qTail] = stAddr;
        qData[qTail] = stData;
        qMask[qTail] = stMask;
        qTail++;
        storeCount++;
      end
    end
  end

  task automatic summary();
    $display("CHECKS %0d ERRORS %0d", checks, errors);
  endtask

  always @(posedge clk) begin
    cyc++;
    if (cyc == 100000 && !done) begin
      errors++;
      $display("FAIL R8 watchdog expired act=%0d exp=%0d", cyc, 0);
      summary();
      $finish;
    end
  end

  task automatic doStore(input int word, input logic [31:0] d, input logic [3:0] m);
    @(negedge clk);
    stValid = 1'b1; stAddr = word * 4; stData = d; stMask = m;
    while (!stReady) @(negedge clk);
    @(negedge clk);
    stValid = 1'b0;
    for (int b = 0; b < 4; b++)
      if (m[b]) shadow[word][8*b +: 8] = d[8*b +: 8];
  endtask

  function automatic logic [31:0] expLoad(input int word, input logic [3:0] m);
    logic [31:0] r;
    for (int b = 0; b < 4; b++) r[8*b +: 8] = m[b] ? shadow[word][8*b +: 8] : 8'h00;
    return r;
  endfunction

  task automatic doLoad(input int word, input logic [3:0] m, input string tag,
                        output logic [31:0] data, output int rdDelta, output int lat);
    int rd0;
    @(negedge clk);
    ldValid = 1'b1; ldAddr = word * 4; ldMask = m;
    while (!ldReady) @(negedge clk);
    rd0 = rdCount;
    @(negedge clk);
    ldValid = 1'b0;
    lat = 1;
    // R8: later operations held off while the load is pending
    if (!ldRespValid)
      check(!stReady && !ldReady, {tag, " R8 readies low during load"},
            {30'h0, stReady, ldReady}, 32'h0);
    while (!ldRespValid && lat < 50) begin @(negedge clk); lat++; end
    data = respData;
    rdDelta = rdCount - rd0;
    check(data == expLoad(word, m), {tag, " load data"}, data, expLoad(word, m));
  endtask

  task automatic waitDrained();
    int n = 0;
    @(negedge clk);
    while (drainValid && n < 2000) begin @(negedge clk); n++; end
  endtask

  initial begin
    logic [31:0] d;
    int rdd, lat, rd0;
    stValid = 0; ldValid = 0; amoValid = 0;
    stAddr = 0; stData = 0; stMask = 0; ldAddr = 0; ldMask = 0;
    amoAddr = 0; amoData = 0; amoOp = 0;
    for (int i = 0; i < 16; i++) begin
      mem[i]    = 32'hA0B0C000 + i * 32'h111;
      shadow[i] = 32'hA0B0C000 + i * 32'h111;
    end
    rst = 1'b1;
    repeat (3) @(posedge clk);
    @(negedge clk);
    rst = 1'b0;

    // R1 reset state
    check(!drainValid && !full && !busy && stReady && !ldRespValid && !amoRespValid,
          "R1 reset state", {26'h0, drainValid, full, busy, stReady, ldRespValid, amoRespValid},
          32'h4);

    // R2 fill the queue with drain stalled
    drainStall = 1'b1;
    for (int w = 0; w < 8; w++) doStore(w, 32'h1000_0000 + w * 32'h0101_0101, 4'hF);
    @(negedge clk);
    check(full && !stReady, "R2 full after eight stores", {30'h0, full, stReady}, 32'h2);

    // R4 load passes queued stores
    doLoad(12, 4'hF, "R4", d, rdd, lat);
    check(rdd == 1, "R4 one read issued", rdd, 1);
    check(full, "R4 stores still queued after load", full, 1);

    // R6 fully covered load
    doLoad(3, 4'hF, "R6", d, rdd, lat);
    check(rdd == 0, "R6 no read for covered load", rdd, 0);
    check(lat == 1, "R6 response cycle after accept", lat, 1);

    // R3 release and drain in order
    drainStall = 1'b0;
    waitDrained();
    check(drainCount == 8 && qHead == qTail, "R3 all eight drained", drainCount, 8);

    // R5 youngest store wins per byte
    drainStall = 1'b1;
    doStore(5, 32'h1122_3344, 4'hF);
    doStore(5, 32'hAAAA_5566, 4'h3);
    doStore(5, 32'h00CC_0000, 4'h4);
    doLoad(5, 4'hF, "R5 youngest", d, rdd, lat);
    check(rdd == 0, "R5 covered by queue", rdd, 0);
    check(d == 32'h11CC_5566, "R5 merged youngest bytes", d, 32'h11CC_5566);

    // R7 partial coverage merge
    doStore(6, 32'h0000_00EE, 4'h1);
    doLoad(6, 4'hF, "R7 partial", d, rdd, lat);
    check(rdd == 1, "R7 read for uncovered bytes", rdd, 1);
    doLoad(6, 4'h2, "R7 masked", d, rdd, lat);
    check(rdd == 1, "R7 read for single uncovered byte", rdd, 1);
    doLoad(6, 4'h1, "R7 covered byte", d, rdd, lat);
    check(rdd == 0, "R7 covered byte no read", rdd, 0);
    drainStall = 1'b0;
    waitDrained();

    // R5 R7 sweep over store and load masks with random drain back-pressure
    jitter = 1'b1;
    for (int sm = 1; sm < 16; sm++) begin
      for (int lm = 1; lm < 16; lm++) begin
        doStore(8 + (sm & 3), 32'h0101_0101 * (sm * 16 + lm), 4'(sm));
        doLoad(8 + (lm & 3), 4'(lm), "R5 R7 sweep", d, rdd, lat);
      end
    end
    jitter = 1'b0;
    waitDrained();

    // R9 R10 atomics behind queued stores
    for (int op = 0; op < 4; op++) begin
      logic [31:0] oldExp, opnd;
      drainStall = 1'b1;
      doStore(13, 32'h5A00_0000 + op, 4'h9);
      doStore(14, 32'h0000_7700 + op, 4'hF);
      doStore(13, 32'h00C3_3C00 * (op + 1), 4'h6);
      oldExp = shadow[13];
      opnd   = 32'h0F0F_1234 + op;
      @(negedge clk);
      amoValid = 1'b1; amoAddr = 13 * 4; amoData = opnd; amoOp = 2'(op);
      while (!amoReady) @(negedge clk);
      rd0 = rdCount;
      @(negedge clk);
      amoValid = 1'b0;
      repeat (4) @(negedge clk);
      check(busy && !rdReqValid && !stReady && !ldReady && rdCount == rd0,
            "R9 atomic waits for drain", {28'h0, busy, rdReqValid, stReady, ldReady}, 32'h8);
      drainStall = 1'b0;
      lat = 0;
      while (!amoRespValid && lat < 200) begin @(negedge clk); lat++; end
      check(amoRespValid && respData == oldExp, "R10 atomic old value", respData, oldExp);
      check(drainsAtAmo == storeCount, "R9 all stores drained before atomic",
            drainsAtAmo, storeCount);
      check(rdCount - rd0 == 1, "R10 single request", rdCount - rd0, 1);
      shadow[13] = amoApply(oldExp, opnd, 2'(op));
      @(negedge clk);
      check(!busy && stReady, "R9 busy clears after response", {30'h0, busy, stReady}, 32'h1);
    end

    // R3 R10 final memory image equals program-order image
    waitDrained();
    for (int i = 0; i < 16; i++)
      check(mem[i] == shadow[i], "R3 R10 final memory word", mem[i], shadow[i]);
    check(qHead == qTail, "R3 every store drained once", qHead, qTail);

    done = 1'b1;
    summary();
    $finish;
  end

endmodule